// File: doc/BRIEF.md
# Scrambled-Map Interrupt Pending Controller

This block gathers 64 interrupt request inputs into latched pending state and gates them with per-source enable bits. It presents the winning source as a six-bit code in a read-only vector register and drives a single combined interrupt line. Pending and enable state is split across two 32-bit words, an upper word and a lower word. A source does not sit at bit N of a flat register. Each source has a fixed word and bit taken from a scatter map, so software needs that map to mask or acknowledge one source.

Requests arrive already qualified as pulses or levels, one bit per source. A request that is high at a rising clock edge sets the pending bit of its source. Software talks to the block over a simple register bus:

- Writing a pending word acknowledges: each 1 written clears that bit.
- Writing a mask word sets the enables directly.
- Reading the vector register tells the handler which source to serve.

Top module: `scatter_irq_ctrl`

## Requirements
- R1: Sources 0-15 and 32-47 live in the upper word. Sources 16-31 and 48-63 live in the lower word. The bit for each source is as follows:
  - source 0 uses bit 0, and source s in 1-15 uses bit 16-s;
  - source s in 16-18 uses bit 18-s, and source s in 19-30 uses bit 33-s;
  - source 31 uses bit 0;
  - source s in 32-47 uses bit 63-s, and source s in 48-63 uses bit s-32.
- R2: A request that is high at a rising clock edge sets its pending bit at that edge. The bit stays set after the request falls.
- R3: Writing a pending word clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: If a request and an acknowledge of the same bit occur in one cycle, the bit ends set.
- R5: A mask bit of 1 enables its source and 0 disables it. A disabled source still latches pending, but it affects neither the vector nor the interrupt output.
- R6: The vector register holds the winning source number in bits 31:26, and bits 25:0 read 0. A code of 0 means that no enabled source is pending.
- R7: The lowest-numbered nonzero enabled pending source wins. Source 31 shares lower bit 0 with source 18, so that bit reports as 18. Source 0 is never reported as a code.
- R8: `irq_o` is the OR of all enabled pending bits, including source 0. It is registered and follows the pending and mask state one cycle later.
- R9: Reading any register, including the vector register, changes no state.
- R10: Reset (synchronous, active high) clears both pending words, both mask words, the vector and `irq_o`.
- R11: The register addresses are:
  - 0: upper pending word
  - 1: lower pending word
  - 2: upper mask word
  - 3: lower mask word
  - 4: vector register

  Read data appears on `bus_rdata` at the edge that takes the read. Writes to address 4 or to unused addresses are ignored, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 64 | Qualified request per source, bit index = source number |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The hardest case to produce from the ports is a request for a bit that lands in the same clock edge as a software acknowledge of that bit. The bench drives the request line and the pending-word write on the same negative edge, so both reach the design at one rising edge.

The shared lower bit 0 is also hard to reach. The bench sweeps every source on its own and every neighbouring pair of sources, so source 31 appears both alone and next to 30 and 32. The expected code is derived arithmetically from the map.

// File: rtl/scirq_pkg.sv
package scirq_pkg;
  localparam int NSRC   = 64;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 3;
  localparam int NWORD  = 2;
  localparam int W_LO   = 0;
  localparam int W_HI   = 1;

  typedef enum logic [ADDR_W-1:0] {
    A_PEND_HI = 3'd0,
    A_PEND_LO = 3'd1,
    A_MASK_HI = 3'd2,
    A_MASK_LO = 3'd3,
    A_VEC     = 3'd4
  } reg_addr_e;

  // Word that holds a source: 1 = upper word, 0 = lower word.
  function automatic int src_word(input int s);
    return ((s < 16) || (s >= 32 && s < 48)) ? W_HI : W_LO;
  endfunction

  // Bit position of a source inside its word.
  function automatic int src_bit(input int s);
    if (s == 0)       return 0;
    else if (s < 16)  return 16 - s;
    else if (s < 19)  return 18 - s;
    else if (s < 31)  return 33 - s;
    else if (s == 31) return 0;
    else if (s < 48)  return 63 - s;
    else              return s - 32;
  endfunction
endpackage

// File: rtl/scirq_route.sv
module scirq_route
  import scirq_pkg::*;
#(
  parameter int N_SRC  = NSRC,
  parameter int WORD_W_P = WORD_W
) (
  input  logic [N_SRC-1:0]                 req_i,
  input  logic [NWORD-1:0][WORD_W_P-1:0]   pend_i,
  input  logic [NWORD-1:0][WORD_W_P-1:0]   mask_i,
  output logic [NWORD-1:0][WORD_W_P-1:0]   set_o,
  output logic [N_SRC-1:0]                 act_o
);
  // Scatter: per-source requests onto word/bit set lines.
  always_comb begin
    set_o = '0;
    for (int s = 0; s < N_SRC; s++) begin
      set_o[src_word(s)][src_bit(s)] = set_o[src_word(s)][src_bit(s)] | req_i[s];
    end
  end

  // Gather: enabled pending state back into source order.
  for (genvar g = 0; g < N_SRC; g++) begin : g_gather
    localparam int WD = src_word(g);
    localparam int BT = src_bit(g);
    assign act_o[g] = pend_i[WD][BT] & mask_i[WD][BT];
  end
endmodule

// File: rtl/scirq_bank.sv
module scirq_bank #(
  parameter int WORD_W_P = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [WORD_W_P-1:0] set_i,
  input  logic                ack_we,
  input  logic                mask_we,
  input  logic [WORD_W_P-1:0] wdata,
  output logic [WORD_W_P-1:0] pend_o,
  output logic [WORD_W_P-1:0] mask_o
);
  logic [WORD_W_P-1:0] clr;
  assign clr = ack_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= '0;
      mask_o <= '0;
    end else begin
      pend_o <= (pend_o & ~clr) | set_i;   // new request beats acknowledge
      if (mask_we) mask_o <= wdata;
    end
  end
endmodule

// File: rtl/scirq_pick.sv
module scirq_pick #(
  parameter int N_SRC = 64,
  localparam int VEC_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] act_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             irq_o
);
  logic [VEC_W-1:0] win;

  always_comb begin
    win = '0;
    for (int s = N_SRC - 1; s >= 1; s--) begin
      if (act_i[s]) win = VEC_W'(s);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_o <= '0;
      irq_o <= 1'b0;
    end else begin
      vec_o <= win;
      irq_o <= |act_i;
    end
  end
endmodule

// File: rtl/scatter_irq_ctrl.sv
module scatter_irq_ctrl
  import scirq_pkg::*;
#(
  parameter int N_SRC    = NSRC,
  parameter int WORD_W_P = WORD_W,
  localparam int VEC_W   = $clog2(N_SRC),
  localparam int VEC_LSB = WORD_W_P - VEC_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_SRC-1:0]    req_i,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W_P-1:0] bus_wdata,
  output logic [WORD_W_P-1:0] bus_rdata,
  output logic                irq_o
);
  logic [NWORD-1:0][WORD_W_P-1:0] pend_w, mask_w, set_w;
  logic [N_SRC-1:0]               act;
  logic [VEC_W-1:0]               vec_q;
  logic                           wr;

  assign wr = bus_en & bus_we;

  scirq_route #(.N_SRC(N_SRC), .WORD_W_P(WORD_W_P)) u_route (
    .req_i (req_i),
    .pend_i(pend_w),
    .mask_i(mask_w),
    .set_o (set_w),
    .act_o (act)
  );

  for (genvar w = 0; w < NWORD; w++) begin : g_bank
    localparam logic [ADDR_W-1:0] PA = (w == W_HI) ? A_PEND_HI : A_PEND_LO;
    localparam logic [ADDR_W-1:0] MA = (w == W_HI) ? A_MASK_HI : A_MASK_LO;
    scirq_bank #(.WORD_W_P(WORD_W_P)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .set_i  (set_w[w]),
      .ack_we (wr && bus_addr == PA),
      .mask_we(wr && bus_addr == MA),
      .wdata  (bus_wdata),
      .pend_o (pend_w[w]),
      .mask_o (mask_w[w])
    );
  end

  scirq_pick #(.N_SRC(N_SRC)) u_pick (
    .clk  (clk),
    .rst  (rst),
    .act_i(act),
    .vec_o(vec_q),
    .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_en && !bus_we) begin
      case (bus_addr)
        A_PEND_HI: bus_rdata <= pend_w[W_HI];
        A_PEND_LO: bus_rdata <= pend_w[W_LO];
        A_MASK_HI: bus_rdata <= mask_w[W_HI];
        A_MASK_LO: bus_rdata <= mask_w[W_LO];
        A_VEC:     bus_rdata <= {vec_q, {VEC_LSB{1'b0}}};
        default:   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/scirq_checker.sv
module scirq_checker
  import scirq_pkg::*;
#(
  parameter int WORD_W_P = 32,
  parameter int VEC_W    = 6
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           bus_en,
  input logic                           bus_we,
  input logic [ADDR_W-1:0]              bus_addr,
  input logic [WORD_W_P-1:0]            bus_wdata,
  input logic [NWORD-1:0][WORD_W_P-1:0] pend_w,
  input logic [NWORD-1:0][WORD_W_P-1:0] mask_w,
  input logic [NWORD-1:0][WORD_W_P-1:0] set_w,
  input logic [VEC_W-1:0]               vec_q,
  input logic                           irq_o
);
  logic armed, rst_d;
  always_ff @(posedge clk) begin
    armed <= !rst;
    rst_d <= rst;
  end

  always_ff @(posedge clk) begin
    if (rst_d === 1'b1) begin
      p_reset_clear_r10: assert (pend_w == '0 && mask_w == '0 && !irq_o && vec_q == '0);
    end
  end

  p_ack_hi_r3: assert property (@(posedge clk) disable iff (rst)
    armed && $past(bus_en && bus_we && bus_addr == 3'(A_PEND_HI))
    |-> ((pend_w[W_HI] & $past(bus_wdata) & ~$past(set_w[W_HI])) == '0));

  p_ack_lo_r3: assert property (@(posedge clk) disable iff (rst)
    armed && $past(bus_en && bus_we && bus_addr == 3'(A_PEND_LO))
    |-> ((pend_w[W_LO] & $past(bus_wdata) & ~$past(set_w[W_LO])) == '0));

  p_set_lands_r4: assert property (@(posedge clk) disable iff (rst)
    armed |-> ((pend_w & $past(set_w)) == $past(set_w)));

  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    armed && $past(mask_w == '0) |-> (!irq_o && vec_q == '0));

  p_vec_needs_irq_r7: assert property (@(posedge clk) disable iff (rst)
    (vec_q != '0) |-> irq_o);

  p_irq_tracks_r8: assert property (@(posedge clk) disable iff (rst)
    armed |-> irq_o == $past(|((pend_w[W_HI] & mask_w[W_HI]) | (pend_w[W_LO] & mask_w[W_LO]))));

  p_mask_hold_r11: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(bus_en && bus_we && (bus_addr == 3'(A_MASK_HI) || bus_addr == 3'(A_MASK_LO)))
    |-> $stable(mask_w));
endmodule

bind scatter_irq_ctrl scirq_checker #(.WORD_W_P(WORD_W_P), .VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_en   (bus_en),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .pend_w   (pend_w),
  .mask_w   (mask_w),
  .set_w    (set_w),
  .vec_q    (vec_q),
  .irq_o    (irq_o)
);

// File: tb/scatter_irq_ctrl_tb.sv
module scatter_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] req_i = '0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  scatter_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .req_i(req_i), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // Expected map from R1: returns 1 for upper word.
  function automatic bit upper(input int s);
    return (s / 16) % 2 == 0;
  endfunction
  function automatic int bitpos(input int s);
    case (s / 16)
      0: return (s == 0) ? 0 : 16 - s;
      1: return (s <= 18) ? 18 - s : ((s == 31) ? 0 : 33 - s);
      2: return 63 - s;
      default: return s - 32;
    endcase
  endfunction
  function automatic int code_of(input int s);
    return (s == 31) ? 18 : s;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic rd_vec(output logic [31:0] d);
    @(negedge clk);
    rd(3'd4, d);
  endtask

  task automatic pulse(input int s);
    req_i[s] = 1'b1;
    @(negedge clk);
    req_i[s] = 1'b0;
  endtask

  task automatic clear_all();
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, d2, ew;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 irq", {31'd0, irq_o}, 32'd0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      check("R10 reg", d, 32'd0);
    end
    // R11 mask write and readback, unused address reads 0
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd2, d); check("R11 mask hi", d, 32'hFFFF_FFFF);
    rd(3'd3, d); check("R11 mask lo", d, 32'hFFFF_FFFF);
    rd(3'd6, d); check("R11 unused", d, 32'd0);

    // R1 R2 R3 R6 R7 R8 R9 sweep over every source
    for (int s = 0; s < 64; s++) begin
      ew = 32'd1 << bitpos(s);
      pulse(s);
      @(negedge clk);
      check("R8 irq set", {31'd0, irq_o}, 32'd1);
      rd(3'd0, d); check("R1 R2 pend hi", d, upper(s) ? ew : 32'd0);
      rd(3'd1, d); check("R1 R2 pend lo", d, upper(s) ? 32'd0 : ew);
      rd_vec(d); check("R6 R7 vector", d, (s == 0) ? 32'd0 : (32'(code_of(s)) << 26));
      rd(3'd4, d2); check("R9 vector reread", d2, d);
      wr(upper(s) ? 3'd0 : 3'd1, 32'd0);
      rd(upper(s) ? 3'd0 : 3'd1, d); check("R3 write zero keeps", d, ew);
      wr(upper(s) ? 3'd0 : 3'd1, ew);
      rd(3'd0, d); check("R3 cleared hi", d, 32'd0);
      rd(3'd1, d); check("R3 cleared lo", d, 32'd0);
      check("R8 irq cleared", {31'd0, irq_o}, 32'd0);
    end

    // R7 neighbouring pairs
    for (int a = 1; a < 63; a++) begin
      int ca, cb, m;
      ca = code_of(a); cb = code_of(a + 1);
      m = (ca < cb) ? ca : cb;
      req_i[a] = 1'b1; req_i[a+1] = 1'b1;
      @(negedge clk);
      req_i = '0;
      rd_vec(d); check("R7 pair winner", d, 32'(m) << 26);
      wr(upper(a) ? 3'd0 : 3'd1, 32'd1 << bitpos(a));
      rd_vec(d); check("R7 after ack", d, 32'(cb) << 26);
      clear_all();
    end

    // R5 masking
    wr(3'd2, 32'd0);
    wr(3'd3, 32'd0);
    pulse(5);
    pulse(40);
    @(negedge clk);
    check("R5 irq masked", {31'd0, irq_o}, 32'd0);
    rd_vec(d); check("R5 vec masked", d, 32'd0);
    rd(3'd0, d); check("R5 pend latched", d, (32'd1 << 11) | (32'd1 << 23));
    wr(3'd2, 32'd1 << 23);
    rd_vec(d); check("R5 only 40 enabled", d, 32'd40 << 26);
    check("R5 irq enabled", {31'd0, irq_o}, 32'd1);
    wr(3'd2, 32'hFFFF_FFFF);
    rd_vec(d); check("R5 all enabled", d, 32'd5 << 26);

    // R11 write to vector address ignored
    wr(3'd4, 32'hFFFF_FFFF);
    rd_vec(d); check("R11 vec write ignored", d, 32'd5 << 26);
    rd(3'd2, d); check("R11 mask kept", d, 32'hFFFF_FFFF);
    clear_all();

    // R4 request and acknowledge on the same edge (source 50 -> lower bit 18)
    wr(3'd3, 32'hFFFF_FFFF);
    req_i[50] = 1'b1;
    wr(3'd1, 32'hFFFF_FFFF);
    req_i[50] = 1'b0;
    rd(3'd1, d); check("R4 set beats ack", d, 32'd1 << 18);
    rd_vec(d); check("R4 vector", d, 32'd50 << 26);
    clear_all();
    rd(3'd1, d); check("R4 cleared later", d, 32'd0);

    // R10 reset mid-run
    pulse(9);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd(3'd0, d); check("R10 pend after reset", d, 32'd0);
    rd(3'd2, d); check("R10 mask after reset", d, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule